// File: doc/BRIEF.md
# Peripheral Clock Control Register Unit

This unit governs the clock and reset of one attached peripheral through a single 32-bit control word. Software writes the word to choose one of up to eight source tick strobes, to set a zero-based fractional ratio, to open or close the output gate, and to take the peripheral out of reset. All sources arrive as single-cycle clock-enable pulses in the system clock domain. The output is a stream of single-cycle ticks.

A phase accumulator scales the tick rate by (FRAC+1)/(PCD+1). Each selected source tick adds the numerator, and the unit emits an output tick whenever the sum reaches the denominator. While the gate is open, the source select and ratio fields are frozen. Software closes the gate, reprograms the fields, and opens the gate again. A write that closes the gate may carry new field values in the same write.

Top module: `pclk_ctrl_unit`

## Requirements
- R1: After reset the control word reads 0x00000000, `tick_out` is 0 and `periph_rst_n` is 0.
- R2: The field layout is: bit 30 gate (1 = open), bit 28 reset release, bits 26:24 source select, bit 3 numerator code FRAC, bits 2:0 denominator code PCD. All other bits read 0 and ignore writes.
- R3: A write made while the stored gate is 1, whose data keeps bit 30 at 1, leaves the source select, FRAC and PCD fields at their old values.
- R4: A write whose bit 30 is 0 stores all of its fields in that same write, whatever the old gate state was.
- R5: Only `src_tick[sel]` advances the divider, where `sel` is the stored bits 26:24. Pulses on the other sources have no effect on `tick_out`.
- R6: When FRAC+1 <= PCD+1 and the gate opens with a cleared accumulator, k selected source ticks produce exactly floor(k*(FRAC+1)/(PCD+1)) output ticks.
- R7: When FRAC+1 > PCD+1, every selected source tick produces exactly one output tick.
- R8: An output tick is a one-cycle pulse. It appears in the cycle after the clock edge that samples the selected source tick with the gate open.
- R9: While the stored gate is 0, `tick_out` stays 0 and the accumulator is cleared, so a later opening starts from phase zero.
- R10: `periph_rst_n` equals stored bit 28, delayed by one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Stored control word |
| src_tick | input | NUM_SRC | Source tick strobes, one per source |
| tick_out | output | 1 | Gated, scaled output tick |
| periph_rst_n | output | 1 | Active-low reset to the peripheral |

## Verification
The bench builds the unit with its defaults: eight sources, a 3-bit denominator code and a 1-bit numerator code. With eight sources, every select code names a real strobe, so all eight inputs are reached. The narrow ratio fields give only sixteen FRAC/PCD pairs, so the bench walks every pair, including the single pair whose ratio exceeds one, while the unselected sources pulse as distractors. Directed runs cover the field lock, a gate-closing write that reprograms the fields, accumulator clearing, pulse timing and reset-release timing.

// File: rtl/pcc_pkg.sv
// Package: shared layout of the peripheral clock control word.
// Assumes a 32-bit word; the field positions are fixed by the software view.
package pcc_pkg;
    localparam int CTRL_W    = 32;
    localparam int GATE_BIT  = 30;
    localparam int RLS_BIT   = 28;
    localparam int SEL_LSB   = 24;
    localparam int SEL_W     = 3;
    localparam int NUM_LSB   = 3;
    localparam int NUM_W     = 1;
    localparam int DEN_LSB   = 0;
    localparam int DEN_W     = 3;

    // Decoded control word.
    typedef struct packed {
        logic             gate;
        logic             rls;
        logic [SEL_W-1:0] sel;
        logic [NUM_W-1:0] num;
        logic [DEN_W-1:0] den;
    } ctrl_t;

    // Place decoded fields at their word positions; every other bit is 0.
    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[GATE_BIT]                = c.gate;
        w[RLS_BIT]                 = c.rls;
        w[SEL_LSB +: SEL_W]        = c.sel;
        w[NUM_LSB +: NUM_W]        = c.num;
        w[DEN_LSB +: DEN_W]        = c.den;
        return w;
    endfunction

    // Pull the decoded fields out of a raw word.
    function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.gate = w[GATE_BIT];
        c.rls  = w[RLS_BIT];
        c.sel  = w[SEL_LSB +: SEL_W];
        c.num  = w[NUM_LSB +: NUM_W];
        c.den  = w[DEN_LSB +: DEN_W];
        return c;
    endfunction
endpackage

// File: rtl/pcc_ctrl_reg.sv
// Module: control word storage with the field lock.
// While the stored gate is open, select and ratio fields are frozen unless the
// same write closes the gate. Gate and reset-release bits are always writable.
module pcc_ctrl_reg
    import pcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [CTRL_W-1:0] rdata
);
    ctrl_t ctrl_q;
    ctrl_t wr_c;
    logic  fields_open;
    logic  unused_wbits;

    // Decode incoming data and decide whether the locked fields may move.
    always_comb begin
        wr_c        = ctrl_unpack(wdata);
        fields_open = !ctrl_q.gate || !wr_c.gate;
    end

    // Bits outside the defined fields are dropped on purpose.
    assign unused_wbits = ^{wdata[31], wdata[29], wdata[27], wdata[23:4]};

    // Register update: gate and release always, fields only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we) begin
            ctrl_q.gate <= wr_c.gate;
            ctrl_q.rls  <= wr_c.rls;
            if (fields_open) begin
                ctrl_q.sel <= wr_c.sel;
                ctrl_q.num <= wr_c.num;
                ctrl_q.den <= wr_c.den;
            end
        end
    end

    assign ctrl  = ctrl_q;
    assign rdata = ctrl_pack(ctrl_q);
endmodule

// File: rtl/pcc_src_sel.sv
// Module: picks one source tick strobe by index.
// Assumes strobes are single-cycle enables in the system clock domain; an
// index beyond the populated sources yields no ticks.
module pcc_src_sel #(
    parameter int NUM_SRC = 8,
    parameter int SEL_W   = 3
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    localparam int SEL_SPAN = 1 << SEL_W;

    generate
        if (NUM_SRC == SEL_SPAN) begin : g_full
            // Every code maps to a real source.
            always_comb tick = src_tick[sel];
        end else begin : g_partial
            // Codes past the last source select nothing.
            logic [SEL_SPAN-1:0] padded;
            always_comb begin
                padded = '0;
                padded[NUM_SRC-1:0] = src_tick;
                tick = padded[sel];
            end
        end
    endgenerate
endmodule

// File: rtl/pcc_frac_div.sv
// Module: zero-based fractional tick divider using a phase accumulator.
// Ratio (num+1)/(den+1); capped at one output per input when above one.
// Accumulator and output are cleared whenever run is low.
module pcc_frac_div #(
    parameter int NUM_W = 1,
    parameter int DEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_in,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             tick_out
);
    localparam int ACC_W = ((DEN_W > NUM_W) ? DEN_W : NUM_W) + 2;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] n_eff;
    logic [ACC_W-1:0] d_eff;
    logic [ACC_W-1:0] sum;
    logic             fast;

    // Effective one-based numerator, denominator and next phase.
    always_comb begin
        n_eff = {{(ACC_W-NUM_W){1'b0}}, num} + 1'b1;
        d_eff = {{(ACC_W-DEN_W){1'b0}}, den} + 1'b1;
        sum   = acc_q + n_eff;
        fast  = n_eff > d_eff;
    end

    // Accumulate per input tick and emit a registered output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            acc_q    <= '0;
            tick_out <= 1'b0;
        end else if (tick_in) begin
            if (fast) begin
                acc_q    <= '0;
                tick_out <= 1'b1;
            end else if (sum >= d_eff) begin
                acc_q    <= sum - d_eff;
                tick_out <= 1'b1;
            end else begin
                acc_q    <= sum;
                tick_out <= 1'b0;
            end
        end else begin
            tick_out <= 1'b0;
        end
    end
endmodule

// File: rtl/pclk_ctrl_unit.sv
// Module: per-peripheral clock control unit (top).
// Holds the control word, selects a source strobe, scales it, gates it and
// drives the peripheral's active-low reset. Single clock domain.
module pclk_ctrl_unit
    import pcc_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               tick_out,
    output logic               periph_rst_n
);
    ctrl_t ctrl;
    logic  sel_tick;

    pcc_ctrl_reg i_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .ctrl  (ctrl),
        .rdata (reg_rdata)
    );

    pcc_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) i_sel (
        .src_tick (src_tick),
        .sel      (ctrl.sel),
        .tick     (sel_tick)
    );

    pcc_frac_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl.gate),
        .tick_in  (sel_tick),
        .num      (ctrl.num),
        .den      (ctrl.den),
        .tick_out (tick_out)
    );

    // Peripheral reset follows the release bit one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) periph_rst_n <= 1'b0;
        else        periph_rst_n <= ctrl.rls;
    end
endmodule

// File: rtl/pcc_checker.sv
// Module: property checker for pclk_ctrl_unit, attached by bind below.
// Observes ports only.
module pcc_checker #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        reg_rdata,
    input logic [NUM_SRC-1:0] src_tick,
    input logic               tick_out,
    input logic               periph_rst_n
);
    localparam logic [31:0] DEF_MASK = 32'h5700_000F;
    logic [7:0] src_pad;
    logic       live_tick;

    // Selected, gated source strobe as seen from the ports.
    always_comb begin
        src_pad = '0;
        src_pad[NUM_SRC-1:0] = src_tick;
        live_tick = src_pad[reg_rdata[26:24]] & reg_rdata[30];
    end

    assert_undef_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~DEF_MASK) == 32'h0);

    assert_fields_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_rdata[30] && reg_wdata[30])
        |=> (reg_rdata[26:24] == $past(reg_rdata[26:24])) && (reg_rdata[3:0] == $past(reg_rdata[3:0])));

    assert_tick_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> $past(live_tick));

    assert_gate_off_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[30] |=> !tick_out);

    assert_reset_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> periph_rst_n == $past(reg_rdata[28]));
endmodule

bind pclk_ctrl_unit pcc_checker #(.NUM_SRC(NUM_SRC)) i_pcc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .src_tick     (src_tick),
    .tick_out     (tick_out),
    .periph_rst_n (periph_rst_n)
);

// File: tb/test_pclk_ctrl_unit.sv
// Bench: vector walk over all ratio codes, then directed corner cases.
module test_pclk_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  src_tick = '0;
    logic        tick_out;
    logic        periph_rst_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Vector: [14:12] sel, [11] FRAC, [10:8] PCD, [7:0] expected ticks over 24 source ticks.
    localparam logic [15:0] VEC [16] = '{
        16'h0018, 16'h310C, 16'h6208, 16'h1306, 16'h4404, 16'h7504, 16'h2603, 16'h5703,
        16'h0818, 16'h3918, 16'h6A10, 16'h1B0C, 16'h4C09, 16'h7D08, 16'h2E06, 16'h5F06
    };

    pclk_ctrl_unit i_pclk_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .src_tick(src_tick), .tick_out(tick_out),
        .periph_rst_n(periph_rst_n)
    );

    always #4 clk = ~clk;

    // Record one comparison.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Build a control word from fields.
    function automatic logic [31:0] cw(input bit g, input bit r, input int s, input int f, input int p);
        return (32'(g) << 30) | (32'(r) << 28) | (32'(s & 7) << 24) | (32'(f & 1) << 3) | 32'(p & 7);
    endfunction

    // One register write; returns at the negedge after the capturing edge.
    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    // Pulse source s n times (others held high) and count output ticks.
    task automatic run_ticks(input int s, input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (tick_out) cnt++;
            src_tick = 8'hFF;
            @(negedge clk);
            if (tick_out) cnt++;
            src_tick = ~(8'h01 << s);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (tick_out) cnt++;
            src_tick = '0;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 tick_out", 32'(tick_out), 32'h0);
        check("R1 periph_rst_n", 32'(periph_rst_n), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: release bit reaches the reset output one cycle after storage
        wr(cw(0, 1, 0, 0, 0));
        check("R10 not yet", 32'(periph_rst_n), 32'h0);
        @(negedge clk);
        check("R10 released", 32'(periph_rst_n), 32'h1);

        // R2: undefined bits read 0
        wr(32'hFFFF_FFFF);
        check("R2 mask", reg_rdata, 32'h5700_000F);
        wr(cw(0, 1, 0, 0, 0));

        // R6/R7/R5: walk every FRAC/PCD pair on rotating sources
        for (int i = 0; i < 16; i++) begin
            int s, f, p, e;
            s = int'(VEC[i][14:12]); f = int'(VEC[i][11]);
            p = int'(VEC[i][10:8]);  e = int'(VEC[i][7:0]);
            wr(cw(0, 1, s, f, p));
            wr(cw(1, 1, s, f, p));
            check("R2 readback", reg_rdata, cw(1, 1, s, f, p));
            run_ticks(s, 24, cnt);
            if (f + 1 > p + 1) check("R7 pass-through count", 32'(cnt), 32'(e));
            else               check("R6 R5 ratio count", 32'(cnt), 32'(e));
            wr(cw(0, 1, s, f, p));
        end

        // R3: locked fields keep old values while the gate stays on
        wr(cw(0, 1, 2, 0, 3));
        wr(cw(1, 1, 2, 0, 3));
        wr(cw(1, 0, 5, 1, 1));
        check("R3 lock", reg_rdata, cw(1, 0, 2, 0, 3));
        run_ticks(2, 8, cnt);
        check("R3 old ratio used", 32'(cnt), 32'd2);

        // R4: closing write stores new fields at once
        wr(cw(0, 1, 5, 1, 1));
        check("R4 same write", reg_rdata, cw(0, 1, 5, 1, 1));

        // R9: no ticks with gate off
        run_ticks(5, 6, cnt);
        check("R9 gated off", 32'(cnt), 32'd0);

        // R9: accumulator cleared by gate off (1/4 ratio, 2+2 ticks)
        wr(cw(0, 1, 1, 0, 3));
        wr(cw(1, 1, 1, 0, 3));
        run_ticks(1, 2, cnt);
        wr(cw(0, 1, 1, 0, 3));
        wr(cw(1, 1, 1, 0, 3));
        run_ticks(1, 2, cnt);
        check("R9 phase cleared", 32'(cnt), 32'd0);

        // R8: single-cycle pulse one cycle after the sampled tick
        wr(cw(0, 1, 1, 0, 0));
        wr(cw(1, 1, 1, 0, 0));
        @(negedge clk);
        src_tick = 8'h02;
        check("R8 before", 32'(tick_out), 32'h0);
        @(negedge clk);
        src_tick = 8'h00;
        check("R8 pulse", 32'(tick_out), 32'h1);
        @(negedge clk);
        check("R8 one cycle", 32'(tick_out), 32'h0);

        // R10: clearing the release bit reasserts reset one cycle later
        wr(cw(1, 0, 1, 0, 0));
        check("R10 still high", 32'(periph_rst_n), 32'h1);
        @(negedge clk);
        check("R10 reasserted", 32'(periph_rst_n), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule